// File: doc/BRIEF.md
# Load/Store Address Generator

This block works out the memory address for a load or store instruction. It also computes the updated base-register value that indexed addressing writes back. On each request it takes:

- a base register value;
- an offset, taken either from a register or from an unsigned immediate;
- a direction select that adds or subtracts the offset;
- an index-timing select, before or after the access;
- a writeback request;
- an access size.

One clock later it presents a registered result: the access address, the new base value, a writeback strobe for the register file, per-byte lane enables for the data bus, and an alignment-error pulse.

Indexing before the access uses the modified base as the address. In that case the new base is written back only when the request asks for it. Indexing after the access uses the unmodified base as the address, and the modified base is always written back. A plain register-indirect access is an index-before access with a zero immediate and no writeback request. Misaligned word and half-word accesses are flagged. They have their writeback and lane enables suppressed, so the pipeline can raise an exception without corrupting the base register.

Top module: `agu_ls_top`

## Requirements
- R1: Every output is registered. `rsp_valid` is high in the cycle after a clock edge that sampled `req_valid` high, and low after an edge that sampled it low.
- R2: When `off_is_reg` is 1 the offset is `reg_off`. When it is 0 the offset is `imm_off`, zero-extended to the address width.
- R3: When `off_sub` is 0 the modified base is base plus offset. When it is 1 the modified base is base minus offset. Both wrap modulo 2^ADDR_W.
- R4: When `pre_index` is 1, `mem_addr` is the modified base. When `pre_index` is 0, `mem_addr` is the unmodified `base_val`.
- R5: `new_base` is the modified base for every accepted request, whatever the index timing.
- R6: For an aligned request, `wb_strobe` is 1 when `pre_index` is 0. When `pre_index` is 1, it follows `wb_req`.
- R7: Size encoding on `acc_size`: 2'b00 is byte, 2'b01 is half-word, 2'b10 and 2'b11 are word. Little-endian lanes are used. A word enables 4'b1111. A half-word enables 4'b0011 when address bit 1 is 0 and 4'b1100 when it is 1. A byte enables only lane `mem_addr[1:0]`.
- R8: A word access whose address bits [1:0] are not zero, or a half-word access whose address bit 0 is 1, sets `align_err` for that one result cycle. It also forces `wb_strobe` to 0 and `lane_en` to 0. `mem_addr` and `new_base` are still reported.
- R9: In a cycle with `rsp_valid` low, `wb_strobe`, `align_err` and `lane_en` are all 0.
- R10: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| base_val | input | ADDR_W | Base register value |
| reg_off | input | ADDR_W | Register offset value |
| imm_off | input | IMM_W | Unsigned immediate offset |
| off_is_reg | input | 1 | 1 selects the register offset |
| off_sub | input | 1 | 1 subtracts the offset |
| pre_index | input | 1 | 1 indexes before the access |
| wb_req | input | 1 | Writeback request for index-before accesses |
| acc_size | input | 2 | Access size code |
| rsp_valid | output | 1 | Result present |
| mem_addr | output | ADDR_W | Access address |
| new_base | output | ADDR_W | Modified base value |
| wb_strobe | output | 1 | Write `new_base` to the base register |
| lane_en | output | DATA_BYTES | Byte-lane enables |
| align_err | output | 1 | Misaligned access pulse |

## Verification
The only state in the block is the result register. A wrong value shows up at the ports in the very next cycle, as a wrong address, base, lane pattern or strobe.

The most damaging faults are swapped index timing, a lost writeback on index-after accesses, and a writeback that survives a misaligned access. These faults leave the address looking plausible and corrupt only the base register. For that reason each directed scenario compares all five result fields at once. Each scenario also confirms that the idle cycle after it is quiet, which exposes an error or strobe that lasts longer than one cycle.

// File: rtl/agu_pkg.sv
package agu_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'b00,
      SZ_HALF = 2'b01,
      SZ_WORD = 2'b10,
      SZ_WRSV = 2'b11
   } acc_size_e;

   localparam int WORD_BYTES = 4;
   localparam int HALF_BYTES = 2;

endpackage

// File: rtl/agu_offset_unit.sv
module agu_offset_unit #(
   parameter int ADDR_W = 32,
   parameter int IMM_W  = 12
) (
   input  logic [ADDR_W-1:0] base_val,
   input  logic [ADDR_W-1:0] reg_off,
   input  logic [IMM_W-1:0]  imm_off,
   input  logic              off_is_reg,
   input  logic              off_sub,
   input  logic              pre_index,
   output logic [ADDR_W-1:0] mod_base,
   output logic [ADDR_W-1:0] acc_addr
);

   initial begin
      if (IMM_W < 1 || IMM_W > ADDR_W)
         $error("agu_offset_unit: IMM_W must be 1..ADDR_W");
   end

   logic [ADDR_W-1:0] imm_ext;
   logic [ADDR_W-1:0] off_val;

   generate
      if (IMM_W == ADDR_W) begin : g_imm_full
         assign imm_ext = imm_off;
      end else begin : g_imm_pad
         assign imm_ext = {{(ADDR_W-IMM_W){1'b0}}, imm_off};
      end
   endgenerate

   always_comb begin
      off_val  = off_is_reg ? reg_off : imm_ext;
      mod_base = off_sub ? (base_val - off_val) : (base_val + off_val);
      acc_addr = pre_index ? mod_base : base_val;
   end

endmodule

// File: rtl/agu_lane_decode.sv
module agu_lane_decode
   import agu_pkg::*;
#(
   parameter int LANES = 4,
   localparam int LB   = $clog2(LANES)
) (
   input  logic [LB-1:0]    addr_lo,
   input  logic [1:0]       size_code,
   output logic [LANES-1:0] lanes,
   output logic             misaligned
);

   initial begin
      if (LANES < WORD_BYTES || (1 << LB) != LANES)
         $error("agu_lane_decode: LANES must be a power of two of at least 4");
   end

   acc_size_e sz;
   assign sz = acc_size_e'(size_code);

   always_comb begin
      unique case (sz)
         SZ_BYTE: misaligned = 1'b0;
         SZ_HALF: misaligned = addr_lo[0];
         default: misaligned = (addr_lo[1:0] != 2'b00);
      endcase
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic hit_b, hit_h, hit_w;
      assign hit_b = (addr_lo == LB'(i));
      assign hit_h = ((addr_lo >> 1) == LB'(i / HALF_BYTES));
      assign hit_w = ((addr_lo >> 2) == LB'(i / WORD_BYTES));
      always_comb begin
         unique case (sz)
            SZ_BYTE: lanes[i] = hit_b;
            SZ_HALF: lanes[i] = hit_h & ~misaligned;
            default: lanes[i] = hit_w & ~misaligned;
         endcase
      end
   end

endmodule

// File: rtl/agu_ls_top.sv
module agu_ls_top
   import agu_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int IMM_W      = 12,
   parameter int DATA_BYTES = 4,
   localparam int LB        = $clog2(DATA_BYTES)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   input  logic [ADDR_W-1:0]     base_val,
   input  logic [ADDR_W-1:0]     reg_off,
   input  logic [IMM_W-1:0]      imm_off,
   input  logic                  off_is_reg,
   input  logic                  off_sub,
   input  logic                  pre_index,
   input  logic                  wb_req,
   input  logic [1:0]            acc_size,
   output logic                  rsp_valid,
   output logic [ADDR_W-1:0]     mem_addr,
   output logic [ADDR_W-1:0]     new_base,
   output logic                  wb_strobe,
   output logic [DATA_BYTES-1:0] lane_en,
   output logic                  align_err
);

   initial begin
      if (ADDR_W < LB + 1)
         $error("agu_ls_top: ADDR_W too small for DATA_BYTES");
   end

   logic [ADDR_W-1:0]     mod_base;
   logic [ADDR_W-1:0]     acc_addr;
   logic [DATA_BYTES-1:0] lanes;
   logic                  mis;
   logic                  wb_want;

   agu_offset_unit #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_off (
      .base_val  (base_val),
      .reg_off   (reg_off),
      .imm_off   (imm_off),
      .off_is_reg(off_is_reg),
      .off_sub   (off_sub),
      .pre_index (pre_index),
      .mod_base  (mod_base),
      .acc_addr  (acc_addr)
   );

   agu_lane_decode #(.LANES(DATA_BYTES)) u_lane (
      .addr_lo   (acc_addr[LB-1:0]),
      .size_code (acc_size),
      .lanes     (lanes),
      .misaligned(mis)
   );

   assign wb_want = (~pre_index | wb_req) & ~mis;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         mem_addr  <= '0;
         new_base  <= '0;
         wb_strobe <= 1'b0;
         lane_en   <= '0;
         align_err <= 1'b0;
      end else begin
         rsp_valid <= req_valid;
         wb_strobe <= req_valid & wb_want;
         align_err <= req_valid & mis;
         lane_en   <= req_valid ? lanes : '0;
         if (req_valid) begin
            mem_addr <= acc_addr;
            new_base <= mod_base;
         end
      end
   end

   // R1: one-cycle registered latency
   p_lat_hi_r1: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   p_lat_lo_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);
   // R4: index-after uses the unmodified base
   p_post_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !pre_index |=> mem_addr == $past(base_val));
   // R6: index-after always writes back when aligned
   p_post_wb_r6: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !pre_index && !mis |=> wb_strobe);
   p_pre_nowb_r6: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && pre_index && !wb_req |=> !wb_strobe);
   // R7: byte access enables exactly one lane
   p_byte_lane_r7: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && acc_size == SZ_BYTE |=> $countones(lane_en) == 1);
   // R8: misalignment pulses error, blocks writeback and lanes
   p_mis_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && mis |=> align_err && !wb_strobe && lane_en == '0);
   // R9: nothing strobes without a result
   p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> !wb_strobe && !align_err && lane_en == '0);

endmodule

// File: tb/agu_ls_top_test.sv
module agu_ls_top_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] base_val = '0;
   logic [31:0] reg_off = '0;
   logic [11:0] imm_off = '0;
   logic        off_is_reg = 1'b0;
   logic        off_sub = 1'b0;
   logic        pre_index = 1'b0;
   logic        wb_req = 1'b0;
   logic [1:0]  acc_size = 2'b10;
   logic        rsp_valid;
   logic [31:0] mem_addr;
   logic [31:0] new_base;
   logic        wb_strobe;
   logic [3:0]  lane_en;
   logic        align_err;

   int n_tests = 0;
   int n_fail  = 0;

   always #5 clk = ~clk;

   agu_ls_top uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .base_val(base_val),
      .reg_off(reg_off), .imm_off(imm_off), .off_is_reg(off_is_reg),
      .off_sub(off_sub), .pre_index(pre_index), .wb_req(wb_req),
      .acc_size(acc_size), .rsp_valid(rsp_valid), .mem_addr(mem_addr),
      .new_base(new_base), .wb_strobe(wb_strobe), .lane_en(lane_en),
      .align_err(align_err)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Drive one request, check the result cycle, then an idle cycle.
   task automatic access(input string tag, input logic [31:0] b, input logic [31:0] r,
                         input logic [11:0] im, input logic isreg, input logic sub,
                         input logic pre, input logic wbq, input logic [1:0] sz);
      logic [31:0] off, upd, addr;
      logic [3:0]  ln;
      logic        mis, wb;
      off  = isreg ? r : {20'd0, im};
      upd  = sub ? b - off : b + off;
      addr = pre ? upd : b;
      case (sz)
         2'b00: begin mis = 1'b0; ln = 4'b0001 << addr[1:0]; end
         2'b01: begin mis = addr[0]; ln = addr[1] ? 4'b1100 : 4'b0011; end
         default: begin mis = (addr[1:0] != 2'b00); ln = 4'b1111; end
      endcase
      if (mis) ln = 4'b0000;
      wb = (!pre || wbq) && !mis;
      @(negedge clk);
      req_valid = 1'b1; base_val = b; reg_off = r; imm_off = im;
      off_is_reg = isreg; off_sub = sub; pre_index = pre; wb_req = wbq; acc_size = sz;
      @(negedge clk);
      req_valid = 1'b0;
      chk({tag, " R1 valid"}, {31'd0, rsp_valid}, 32'd1);
      chk({tag, " R2/R3/R4 addr"}, mem_addr, addr);
      chk({tag, " R5 base"}, new_base, upd);
      chk({tag, " R6 wb"}, {31'd0, wb_strobe}, {31'd0, wb});
      chk({tag, " R7 lanes"}, {28'd0, lane_en}, {28'd0, ln});
      chk({tag, " R8 err"}, {31'd0, align_err}, {31'd0, mis});
      @(negedge clk);
      chk({tag, " R1 idle valid"}, {31'd0, rsp_valid}, 32'd0);
      chk({tag, " R9 idle quiet"}, {29'd0, wb_strobe, align_err, |lane_en}, 32'd0);
   endtask

   task automatic t_reset;
      chk("R10 rsp_valid", {31'd0, rsp_valid}, 32'd0);
      chk("R10 mem_addr", mem_addr, 32'd0);
      chk("R10 new_base", new_base, 32'd0);
      chk("R10 strobes", {29'd0, wb_strobe, align_err, |lane_en}, 32'd0);
   endtask

   task automatic t_indirect;
      access("R4 indirect", 32'h0000_2000, 32'h0, 12'd0, 1'b0, 1'b0, 1'b1, 1'b0, 2'b10);
   endtask

   task automatic t_base_imm;
      access("R4 base+16", 32'h0000_2000, 32'h0, 12'd16, 1'b0, 1'b0, 1'b1, 1'b0, 2'b10);
      access("R2 imm zext", 32'h0000_1000, 32'h0, 12'hFFF, 1'b0, 1'b0, 1'b1, 1'b0, 2'b00);
   endtask

   task automatic t_reg_sub_wb;
      access("R3 reg sub wb", 32'h0000_3000, 32'h0000_0040, 12'd7, 1'b1, 1'b1, 1'b1, 1'b1, 2'b10);
      access("R3 wrap", 32'h0000_0000, 32'h0000_0004, 12'd0, 1'b1, 1'b1, 1'b1, 1'b1, 2'b10);
   endtask

   task automatic t_post;
      access("R6 post imm", 32'h0000_4000, 32'h0, 12'd16, 1'b0, 1'b0, 1'b0, 1'b0, 2'b10);
      access("R5 post sub", 32'h0000_4004, 32'h0000_0100, 12'd0, 1'b1, 1'b1, 1'b0, 1'b1, 2'b01);
   endtask

   task automatic t_lanes;
      access("R7 half low", 32'h0000_5000, 32'h0, 12'd0, 1'b0, 1'b0, 1'b1, 1'b0, 2'b01);
      access("R7 half high", 32'h0000_5000, 32'h0, 12'd2, 1'b0, 1'b0, 1'b1, 1'b0, 2'b01);
      for (int k = 0; k < 4; k++)
         access("R7 byte", 32'h0000_5000, 32'h0, 12'(k), 1'b0, 1'b0, 1'b1, 1'b1, 2'b00);
      access("R7 size11 word", 32'h0000_5008, 32'h0, 12'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b11);
   endtask

   task automatic t_misalign;
      access("R8 word mis", 32'h0000_1000, 32'h0, 12'd2, 1'b0, 1'b0, 1'b1, 1'b1, 2'b10);
      access("R8 half mis post", 32'h0000_1001, 32'h0, 12'd4, 1'b0, 1'b0, 1'b0, 1'b0, 2'b01);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL watchdog R1 actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_indirect();
      t_base_imm();
      t_reg_sub_wb();
      t_post();
      t_lanes();
      t_misalign();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule